// File: doc/BRIEF.md
# Iterative Floating-Point Divider

This unit divides one unpacked floating-point operand by another. Each operand arrives as a class code, a sign, a two's-complement exponent and a mantissa whose most significant bit is the explicit leading one. The caller pulses `start` with both operands on the inputs. When either operand is zero, infinite or a NaN, the result is settled in one clock. When both operands are normal numbers, a restoring divider produces one quotient bit per clock.

The first step of a normal divide picks between X − Y and 2X − Y. That choice fixes the result exponent, so the quotient never needs a normalization shift afterwards. The mantissa width `MW` already counts the guard and round bits. The sticky bit shows whether the final remainder is non-zero. Rounding and repacking are left to the stages that follow.

The result, the sticky bit and the exception flags stay on the outputs from one `done` pulse until the next accepted operation completes.

Top module: `fp_div_iter`

## Requirements
- R1: Class codes are 0 zero, 1 normal, 2 infinity, 3 quiet NaN, 4 signalling NaN. A normal mantissa has bit MW-1 set. `q_flags` bit 0 is signalling-NaN invalid, bit 1 is infinity/infinity invalid, bit 2 is zero/zero invalid and bit 3 is divide by zero. After reset all outputs are zero and `done` is low.
- R2: For normal/normal, with integer mantissas X and Y, `q_man` is floor(X·2^(MW-1)/Y) when X ≥ Y, and floor(X·2^MW/Y) otherwise. The class is normal and bit MW-1 of `q_man` is always set.
- R3: The normal result exponent is a_exp − b_exp when X ≥ Y and a_exp − b_exp − 1 otherwise, taken modulo 2^EW.
- R4: The normal result's `q_sticky` is 1 exactly when the remainder of the R2 division is non-zero. It is 0 for every special result.
- R5: Every result that is not a NaN carries the sign a_sgn XOR b_sgn.
- R6: If either operand is a NaN, the result is one of the operands, copied unchanged. The choice order is: a signalling divisor, then a signalling dividend, then a quiet divisor, then the dividend. Flag bit 0 is raised when either operand is signalling.
- R7: Infinity/infinity and zero/zero return the default NaN (class 3, sign 0, exponent 0, mantissa 0) and raise flag bit 1 or flag bit 2 respectively.
- R8: Infinity divided by zero or by a normal gives infinity. Zero divided by a normal or by infinity gives zero. A normal divided by infinity gives zero. A normal divided by zero gives infinity and raises flag bit 3. Special results have exponent 0 and mantissa 0.
- R9: `done` is high for exactly the one cycle in which the results first appear. That cycle is 1 cycle after the start cycle for special operands, and MW+1 cycles after it for a normal/normal divide.
- R10: A `start` during a normal divide in progress is ignored. All outputs hold their values between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| a_cls | input | 3 | Dividend class |
| a_sgn | input | 1 | Dividend sign |
| a_exp | input | EW | Dividend exponent |
| a_man | input | MW | Dividend mantissa |
| b_cls | input | 3 | Divisor class |
| b_sgn | input | 1 | Divisor sign |
| b_exp | input | EW | Divisor exponent |
| b_man | input | MW | Divisor mantissa |
| done | output | 1 | Result valid pulse |
| q_cls | output | 3 | Result class |
| q_sgn | output | 1 | Result sign |
| q_exp | output | EW | Result exponent |
| q_man | output | MW | Quotient mantissa with guard and round bits |
| q_sticky | output | 1 | Remainder non-zero |
| q_flags | output | 4 | Exception flags |

## Verification
A special-class result is due exactly one cycle after its start cycle, and a normal divide is due MW+1 cycles after it. For each accepted start the bench records the cycle number at which the result is due. On every falling edge it requires `done` to be high in that cycle and low in every other cycle. The result fields are compared only in the due cycle, against a long-division model. A few cycles later they are compared again, to confirm that they hold and that a start ignored while busy has changed nothing.

// File: rtl/fp_div_iter.sv
module fp_div_iter #(
  parameter int MW = 16,
  parameter int EW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    a_cls,
  input  logic          a_sgn,
  input  logic [EW-1:0] a_exp,
  input  logic [MW-1:0] a_man,
  input  logic [2:0]    b_cls,
  input  logic          b_sgn,
  input  logic [EW-1:0] b_exp,
  input  logic [MW-1:0] b_man,
  output logic          done,
  output logic [2:0]    q_cls,
  output logic          q_sgn,
  output logic [EW-1:0] q_exp,
  output logic [MW-1:0] q_man,
  output logic          q_sticky,
  output logic [3:0]    q_flags
);
  localparam logic [2:0] CZ = 3'd0, CN = 3'd1, CI = 3'd2, CQ = 3'd3, CS = 3'd4;
  localparam int CW = $clog2(MW);

  logic          busy, init, sg;
  logic [CW-1:0] cnt, idx;
  logic [MW-1:0] x, y, quo;
  logic [MW:0]   rem, d1, d2, rn;
  logic [MW+1:0] ds;
  logic [EW-1:0] ex;

  assign d1  = {1'b0, x} - {1'b0, y};
  assign d2  = {x, 1'b0} - {1'b0, y};
  assign ds  = {rem, 1'b0} - {2'b0, y};
  assign rn  = ds[MW+1] ? {rem[MW-1:0], 1'b0} : ds[MW:0];
  assign idx = cnt - 1'b1;

  logic          both_norm, a_nan, b_nan, sx;
  logic [2:0]    s_cls;
  logic          s_sgn;
  logic [EW-1:0] s_exp;
  logic [MW-1:0] s_man;
  logic [3:0]    s_flg;

  assign both_norm = (a_cls == CN) && (b_cls == CN);
  assign a_nan = (a_cls == CQ) || (a_cls == CS);
  assign b_nan = (b_cls == CQ) || (b_cls == CS);
  assign sx    = a_sgn ^ b_sgn;

  always_comb begin
    s_cls = CZ; s_sgn = sx; s_exp = '0; s_man = '0; s_flg = '0;
    if (a_nan || b_nan) begin
      s_flg[0] = (a_cls == CS) || (b_cls == CS);
      if ((b_cls == CS) || (a_cls != CS && b_nan)) begin
        s_cls = b_cls; s_sgn = b_sgn; s_exp = b_exp; s_man = b_man;
      end else begin
        s_cls = a_cls; s_sgn = a_sgn; s_exp = a_exp; s_man = a_man;
      end
    end else if (a_cls == CI) begin
      if (b_cls == CI) begin s_cls = CQ; s_sgn = 1'b0; s_flg[1] = 1'b1; end
      else s_cls = CI;
    end else if (a_cls == CZ) begin
      if (b_cls == CZ) begin s_cls = CQ; s_sgn = 1'b0; s_flg[2] = 1'b1; end
      else s_cls = CZ;
    end else if (b_cls == CI) begin
      s_cls = CZ;
    end else if (b_cls == CZ) begin
      s_cls = CI; s_flg[3] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; init <= 1'b0; sg <= 1'b0; cnt <= '0;
      x <= '0; y <= '0; quo <= '0; rem <= '0; ex <= '0;
      done <= 1'b0; q_cls <= CZ; q_sgn <= 1'b0; q_exp <= '0;
      q_man <= '0; q_sticky <= 1'b0; q_flags <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        if (both_norm) begin
          busy <= 1'b1; init <= 1'b1;
          x <= a_man; y <= b_man; sg <= sx; ex <= a_exp - b_exp;
        end else begin
          done <= 1'b1; q_cls <= s_cls; q_sgn <= s_sgn; q_exp <= s_exp;
          q_man <= s_man; q_sticky <= 1'b0; q_flags <= s_flg;
        end
      end else if (busy) begin
        if (init) begin
          init <= 1'b0;
          cnt  <= CW'(MW - 1);
          quo  <= {1'b1, {(MW-1){1'b0}}};
          if (!d1[MW]) rem <= d1;
          else begin rem <= d2; ex <= ex - EW'(1); end
        end else begin
          quo[idx] <= !ds[MW+1];
          rem <= rn;
          cnt <= idx;
          if (cnt == CW'(1)) begin
            busy <= 1'b0; done <= 1'b1;
            q_cls <= CN; q_sgn <= sg; q_exp <= ex;
            q_man <= {quo[MW-1:1], !ds[MW+1]};
            q_sticky <= |rn; q_flags <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fp_div_iter_chk.sv
module fp_div_iter_chk #(
  parameter int MW = 16,
  parameter int EW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic [2:0]    a_cls,
  input logic [2:0]    b_cls,
  input logic          done,
  input logic [2:0]    q_cls,
  input logic          q_sgn,
  input logic [EW-1:0] q_exp,
  input logic [MW-1:0] q_man,
  input logic          q_sticky,
  input logic [3:0]    q_flags
);
  logic [31:0] age;
  logic        take_norm, take_spec;
  assign take_norm = !busy && start && a_cls == 3'd1 && b_cls == 3'd1;
  assign take_spec = !busy && start && !(a_cls == 3'd1 && b_cls == 3'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (take_norm) age <= 32'd1;
    else if (done) age <= '0;
    else if (age != 0) age <= age + 32'd1;
  end

  AST_NORMAL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    age == 32'(MW + 1) |-> done);                                    // R9
  AST_SPECIAL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    take_spec |=> done);                                              // R9
  AST_QUOTIENT_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
    done && q_cls == 3'd1 |-> q_man[MW-1]);                           // R2
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot0(q_flags));                                      // R7
  AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({q_cls, q_sgn, q_exp, q_man, q_sticky, q_flags})); // R10
endmodule

bind fp_div_iter fp_div_iter_chk #(.MW(MW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .a_cls(a_cls), .b_cls(b_cls), .done(done), .q_cls(q_cls),
  .q_sgn(q_sgn), .q_exp(q_exp), .q_man(q_man), .q_sticky(q_sticky),
  .q_flags(q_flags)
);

// File: tb/fp_div_iter_tb.sv
module fp_div_iter_tb_top;
  localparam int MW = 16;
  localparam int EW = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] a_cls = '0, b_cls = '0;
  logic a_sgn = 1'b0, b_sgn = 1'b0;
  logic [EW-1:0] a_exp = '0, b_exp = '0;
  logic [MW-1:0] a_man = '0, b_man = '0;
  logic done, q_sgn, q_sticky;
  logic [2:0] q_cls;
  logic [EW-1:0] q_exp;
  logic [MW-1:0] q_man;
  logic [3:0] q_flags;

  fp_div_iter #(.MW(MW), .EW(EW)) dut_i (.*);

  always #4 clk = ~clk;

  int cyc = 0, total = 0, bad = 0, due = 0;
  bit pend = 0;
  string tag = "R1";
  logic [2:0] e_cls; logic e_sgn, e_stk; logic [EW-1:0] e_exp;
  logic [MW-1:0] e_man; logic [3:0] e_flg;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic cmp_all(input string t);
    chk(q_cls == e_cls, t, q_cls, e_cls);
    chk(q_sgn == e_sgn, (e_cls == 3 || e_cls == 4) ? t : "R5", q_sgn, e_sgn);
    chk(q_exp == e_exp, t == "R2" ? "R3" : t, q_exp, e_exp);
    chk(q_man == e_man, t, q_man, e_man);
    chk(q_sticky == e_stk, "R4", q_sticky, e_stk);
    chk(q_flags == e_flg, t, q_flags, e_flg);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (done) begin
      chk(pend && cyc == due, "R9", cyc, due);
      if (pend && cyc == due) begin cmp_all(tag); pend = 0; end
    end else if (pend && cyc == due) begin
      chk(0, "R9", 0, 1);
      pend = 0;
    end
  end

  task automatic model;
    bit an, bn;
    longint num, qv;
    an = (a_cls == 3 || a_cls == 4); bn = (b_cls == 3 || b_cls == 4);
    e_cls = 0; e_sgn = a_sgn ^ b_sgn; e_exp = 0; e_man = 0; e_stk = 0; e_flg = 0;
    if (an || bn) begin
      tag = "R6";
      e_flg[0] = (a_cls == 4 || b_cls == 4);
      if (b_cls == 4 || (a_cls != 4 && bn)) begin
        e_cls = b_cls; e_sgn = b_sgn; e_exp = b_exp; e_man = b_man;
      end else begin
        e_cls = a_cls; e_sgn = a_sgn; e_exp = a_exp; e_man = a_man;
      end
    end else if (a_cls == 2 && b_cls == 2) begin
      tag = "R7"; e_cls = 3; e_sgn = 0; e_flg[1] = 1;
    end else if (a_cls == 0 && b_cls == 0) begin
      tag = "R7"; e_cls = 3; e_sgn = 0; e_flg[2] = 1;
    end else if (a_cls == 2) begin tag = "R8"; e_cls = 2;
    end else if (a_cls == 0) begin tag = "R8"; e_cls = 0;
    end else if (b_cls == 2) begin tag = "R8"; e_cls = 0;
    end else if (b_cls == 0) begin tag = "R8"; e_cls = 2; e_flg[3] = 1;
    end else begin
      tag = "R2"; e_cls = 1;
      if (a_man >= b_man) begin num = longint'(a_man) << (MW - 1); e_exp = a_exp - b_exp; end
      else begin num = longint'(a_man) << MW; e_exp = a_exp - b_exp - 1'b1; end
      qv = num / longint'(b_man);
      e_man = qv[MW-1:0];
      e_stk = (num % longint'(b_man)) != 0;
    end
  endtask

  task automatic drive(input [2:0] ac, input as_, input [EW-1:0] ae, input [MW-1:0] am,
                       input [2:0] bc, input bs, input [EW-1:0] be, input [MW-1:0] bm);
    a_cls = ac; a_sgn = as_; a_exp = ae; a_man = am;
    b_cls = bc; b_sgn = bs; b_exp = be; b_man = bm;
  endtask

  task automatic issue(input [2:0] ac, input as_, input [EW-1:0] ae, input [MW-1:0] am,
                       input [2:0] bc, input bs, input [EW-1:0] be, input [MW-1:0] bm);
    wait (!pend);
    @(negedge clk); #1;
    drive(ac, as_, ae, am, bc, bs, be, bm);
    model();
    due = cyc + ((ac == 1 && bc == 1) ? MW + 1 : 1);
    pend = 1; start = 1;
    @(negedge clk); #1;
    start = 0;
  endtask

  function automatic logic [MW-1:0] rman(input logic [2:0] c);
    logic [MW-1:0] m;
    m = MW'($urandom);
    if (c == 1) m[MW-1] = 1'b1;
    return m;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done == 0, "R1", done, 0);
    chk(q_cls == 0, "R1", q_cls, 0);
    chk(q_man == 0, "R1", q_man, 0);
    chk(q_flags == 0 && q_sticky == 0, "R1", q_flags, 0);
    rst_n = 1;
    // R2 R3 R4 directed corners
    issue(1, 0, 10'd5, 16'h8000, 1, 0, 10'd3, 16'h8000);
    issue(1, 1, 10'd0, 16'hFFFF, 1, 0, 10'd1, 16'h8000);
    issue(1, 0, 10'd1, 16'h8000, 1, 1, 10'd0, 16'hFFFF);
    issue(1, 1, 10'h200, 16'hC000, 1, 1, 10'h1FF, 16'hC001);
    issue(1, 0, 10'd7, 16'hAAAA, 1, 0, 10'd7, 16'hAAAA);
    for (int i = 0; i < 40; i++)
      issue(1, 1'($urandom), EW'($urandom), rman(1), 1, 1'($urandom), EW'($urandom), rman(1));
    // R5 R6 R7 R8 every class pair
    for (int r = 0; r < 2; r++)
      for (int ac = 0; ac < 5; ac++)
        for (int bc = 0; bc < 5; bc++)
          issue(3'(ac), 1'($urandom), EW'($urandom), rman(3'(ac)),
                3'(bc), 1'($urandom), EW'($urandom), rman(3'(bc)));
    // R10 start during a normal divide is ignored, outputs then hold
    issue(1, 0, 10'd9, 16'h9234, 1, 1, 10'd2, 16'hE001);
    repeat (2) @(negedge clk);
    #1; drive(2, 0, 0, 0, 2, 0, 0, 0); start = 1;
    @(negedge clk); #1; start = 0;
    drive(0, 1, 10'd3, 16'h1234, 0, 1, 10'd3, 16'h4321);
    wait (!pend);
    repeat (4) @(negedge clk);
    chk(done == 0, "R10", done, 0);
    cmp_all("R10");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule